// File: doc/BRIEF.md
# Fractional Feedback Ratio Reducer

The block takes a requested fractional feedback setting for a synthesizer loop. The setting has an integer part, a numerator and a modulus. The block brings the numerator/modulus pair to lowest terms, because a smaller modulus means weaker fractional spurs. It then checks the integer part and the prescaler choice against the loop's limits and reports the result on registered outputs.

The reduction is iterative. A subtractive greatest-common-divisor engine takes one step per clock. Two restoring dividers then work in parallel to divide the numerator and the modulus by the common factor. When a low-spur setting is requested and the reduced modulus ends up under the floor of 50, the pair is scaled back up by the smallest whole factor that reaches the floor.

A request is issued with a one-cycle `start`. The block raises `busy` until it gives a one-cycle `done`. All results change only on the `done` cycle and hold until the next one.

Top module: `frac_ratio_reducer`

## Requirements
- R1: For a valid request without low-spur, `frac_out`/`mod_out` equal `frac_in`/`mod_in`, each divided by their greatest common divisor.
- R2: `int_mode` is 1 exactly when `frac_in` is 0. Without low-spur, such a request yields `frac_out`=0 and `mod_out`=1.
- R3: A `mod_in` of 0 or 1 sets `err_invalid`. No reduction and no low-spur rescale take place, and `frac_out`/`mod_out` return the inputs unchanged.
- R4: `err_n_min` is set when `n_int` is below 23 with the 4/5 prescaler selected (`presc_89_sel`=0), or below 75 with the 8/9 prescaler selected (`presc_89_sel`=1).
- R5: The prescaler-input threshold is 3000 MHz when `variant_sel`=0 and 3600 MHz when `variant_sel`=1. `err_presc` is set when `presc_in_mhz` is strictly above the threshold and the 4/5 prescaler is selected.
- R6: `legal_45` is 1 when `n_int`>=23 and `presc_in_mhz` is not above the threshold. `legal_89` is 1 when `n_int`>=75. Both flags are independent of `presc_89_sel`.
- R7: With `low_spur_req`=1, a reduced modulus below 50 is multiplied, together with the numerator, by the smallest integer that brings the modulus to at least 50. `err_low_spur` is set only if that product would exceed 4095, so it stays 0 at 12-bit width.
- R8: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after acceptance until `done`. A `start` seen while `busy` is high is ignored.
- R9: After reset, `busy`, `done` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| n_int | input | 16 | Integer part of the division ratio |
| frac_in | input | 12 | Requested numerator |
| mod_in | input | 12 | Requested modulus |
| low_spur_req | input | 1 | Enforce the modulus floor of 50 |
| presc_89_sel | input | 1 | 1 selects the 8/9 prescaler, 0 selects 4/5 |
| variant_sel | input | 1 | Selects the prescaler-input threshold (0: 3000 MHz, 1: 3600 MHz) |
| presc_in_mhz | input | 14 | Prescaler input frequency in MHz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| frac_out | output | 12 | Reduced (or rescaled) numerator |
| mod_out | output | 12 | Reduced (or rescaled) modulus |
| int_mode | output | 1 | Numerator is zero |
| err_invalid | output | 1 | Modulus below 2 |
| err_n_min | output | 1 | Integer part below the minimum for the selected prescaler |
| err_presc | output | 1 | Prescaler input too fast for the 4/5 prescaler |
| legal_45 | output | 1 | 4/5 prescaler usable |
| legal_89 | output | 1 | 8/9 prescaler usable |
| err_low_spur | output | 1 | Low-spur floor not reachable within the modulus range |

## Verification
An error in the divisor search or in the divider shows up as a modulus that has not been fully reduced, or as a numerator/modulus pair with the wrong ratio. Both appear in the same `done` cycle in which the result is reported. A wrong transition in the controller shows up as a missing or doubled `done`, a `busy` that never drops, or a result taken from a request that arrived while the block was busy. Each of these is visible within one request's latency. Mistakes in the threshold or in the minimum integer part appear only at the exact boundary values. The vectors therefore place `n_int` and `presc_in_mhz` on and next to those edges.

// File: rtl/frr_pkg.sv
package frr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GCD,
    ST_DIV,
    ST_SCALE,
    ST_FIN
  } frr_state_e;

  localparam int MIN_N_DUAL = 23;
  localparam int MIN_N_OCT  = 75;
  localparam int THR_LOW_MHZ  = 3000;
  localparam int THR_HIGH_MHZ = 3600;

  // smallest legal integer part for the chosen prescaler
  function automatic int min_n_for(input logic sel_89);
    return sel_89 ? MIN_N_OCT : MIN_N_DUAL;
  endfunction

  // highest prescaler input frequency the 4/5 prescaler tolerates
  function automatic int presc_limit(input logic variant);
    return variant ? THR_HIGH_MHZ : THR_LOW_MHZ;
  endfunction

endpackage

// File: rtl/frr_gcd.sv
module frr_gcd #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] g
);

  logic [W-1:0] a_q, b_q;
  logic         run_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        a_q   <= a_in;
        b_q   <= b_in;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (b_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else if (a_q >= b_q) begin
          a_q <= a_q - b_q;
        end else begin
          a_q <= b_q;
          b_q <= a_q;
        end
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign g    = a_q;

  AST_GCD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> g != '0); // R1

endmodule

// File: rtl/frr_divider.sv
module frr_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/frac_ratio_reducer.sv
module frac_ratio_reducer
  import frr_pkg::*;
#(
  parameter int FW       = 12,
  parameter int NW       = 16,
  parameter int PW       = 14,
  parameter int LS_FLOOR = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] n_int,
  input  logic [FW-1:0] frac_in,
  input  logic [FW-1:0] mod_in,
  input  logic          low_spur_req,
  input  logic          presc_89_sel,
  input  logic          variant_sel,
  input  logic [PW-1:0] presc_in_mhz,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] frac_out,
  output logic [FW-1:0] mod_out,
  output logic          int_mode,
  output logic          err_invalid,
  output logic          err_n_min,
  output logic          err_presc,
  output logic          legal_45,
  output logic          legal_89,
  output logic          err_low_spur
);

  localparam logic [FW-1:0] LS_MIN  = FW'(LS_FLOOR);
  localparam logic [FW:0]   MOD_TOP = {1'b0, {FW{1'b1}}};
  localparam int            LANES   = 2;

  frr_state_e state_q;

  logic [NW-1:0] n_q;
  logic [PW-1:0] pin_q;
  logic [FW-1:0] frac_q, mod_q;
  logic          ls_q, p89_q, var_q, inv_q, ls_err_q;
  logic [FW-1:0] fr_w, md_w, fr_b, md_b;

  // named internal events
  logic          accept, in_invalid, gcd_go, gcd_done, gcd_busy;
  logic [FW-1:0] g;
  logic [LANES-1:0]         div_done;
  logic [LANES-1:0][FW-1:0] div_num, div_quo;
  logic          need_scale, needs_89;
  logic [FW:0]   md_next, fr_next;

  assign accept     = (state_q == ST_IDLE) && start;
  assign in_invalid = mod_in < FW'(2);
  assign gcd_go     = accept && !in_invalid;

  frr_gcd #(.W(FW)) u_gcd (
    .clk(clk), .rst_n(rst_n), .go(gcd_go),
    .a_in(mod_in), .b_in(frac_in),
    .busy(gcd_busy), .done(gcd_done), .g(g)
  );

  assign div_num[0] = frac_q;
  assign div_num[1] = mod_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    frr_divider #(.W(FW)) u_div (
      .clk(clk), .rst_n(rst_n), .go(gcd_done),
      .num(div_num[i]), .den(g),
      .done(div_done[i]), .quo(div_quo[i])
    );
  end

  assign need_scale = ls_q && (md_w < LS_MIN);
  assign md_next    = {1'b0, md_w} + {1'b0, md_b};
  assign fr_next    = {1'b0, fr_w} + {1'b0, fr_b};
  assign needs_89   = pin_q > PW'(presc_limit(var_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      n_q          <= '0;
      pin_q        <= '0;
      frac_q       <= '0;
      mod_q        <= '0;
      ls_q         <= 1'b0;
      p89_q        <= 1'b0;
      var_q        <= 1'b0;
      inv_q        <= 1'b0;
      ls_err_q     <= 1'b0;
      fr_w         <= '0;
      md_w         <= '0;
      fr_b         <= '0;
      md_b         <= '0;
      done         <= 1'b0;
      frac_out     <= '0;
      mod_out      <= '0;
      int_mode     <= 1'b0;
      err_invalid  <= 1'b0;
      err_n_min    <= 1'b0;
      err_presc    <= 1'b0;
      legal_45     <= 1'b0;
      legal_89     <= 1'b0;
      err_low_spur <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          n_q      <= n_int;
          pin_q    <= presc_in_mhz;
          frac_q   <= frac_in;
          mod_q    <= mod_in;
          ls_q     <= low_spur_req;
          p89_q    <= presc_89_sel;
          var_q    <= variant_sel;
          inv_q    <= in_invalid;
          ls_err_q <= 1'b0;
          fr_w     <= frac_in;
          md_w     <= mod_in;
          state_q  <= in_invalid ? ST_FIN : ST_GCD;
        end
        ST_GCD: if (gcd_done) state_q <= ST_DIV;
        ST_DIV: if (div_done[0]) begin
          fr_w    <= div_quo[0];
          md_w    <= div_quo[1];
          fr_b    <= div_quo[0];
          md_b    <= div_quo[1];
          state_q <= ST_SCALE;
        end
        ST_SCALE: begin
          if (!need_scale) begin
            state_q <= ST_FIN;
          end else if (md_next > MOD_TOP) begin
            ls_err_q <= 1'b1;
            state_q  <= ST_FIN;
          end else begin
            md_w <= md_next[FW-1:0];
            fr_w <= fr_next[FW-1:0];
          end
        end
        ST_FIN: begin
          frac_out     <= fr_w;
          mod_out      <= md_w;
          int_mode     <= frac_q == '0;
          err_invalid  <= inv_q;
          err_n_min    <= n_q < NW'(min_n_for(p89_q));
          err_presc    <= !p89_q && needs_89;
          legal_45     <= (n_q >= NW'(min_n_for(1'b0))) && !needs_89;
          legal_89     <= n_q >= NW'(min_n_for(1'b1));
          err_low_spur <= ls_err_q;
          done         <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = state_q != ST_IDLE;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mod_q) && $stable(frac_q)); // R8
  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    div_done[0] |-> ({{FW{1'b0}}, div_quo[0]} * {{FW{1'b0}}, g} == {{FW{1'b0}}, frac_q})
                 && ({{FW{1'b0}}, div_quo[1]} * {{FW{1'b0}}, g} == {{FW{1'b0}}, mod_q})); // R1
  AST_MOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err_invalid |-> mod_out != '0); // R1
  AST_INT_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && int_mode && !err_invalid |-> frac_out == '0); // R2
  AST_LS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    done && ls_q && !err_invalid && !err_low_spur |-> mod_out >= LS_MIN); // R7
  AST_GCD_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gcd_busy |-> busy); // R8

endmodule

// File: tb/frac_ratio_reducer_test.sv
module frac_ratio_reducer_test;

  typedef struct packed {
    logic [15:0] n;
    logic [11:0] fr;
    logic [11:0] md;
    logic        ls;
    logic        p89;
    logic        vr;
    logic [13:0] pin;
    logic [11:0] efr;
    logic [11:0] emd;
    logic [6:0]  efl; // {int, inv, nmin, presc, l45, l89, lserr}
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'd100, 12'd6,    12'd8,    1'b0, 1'b1, 1'b0, 14'd4000, 12'd3,    12'd4,    7'b0000010},
    '{16'd50,  12'd0,    12'd25,   1'b0, 1'b0, 1'b1, 14'd3500, 12'd0,    12'd1,    7'b1000100},
    '{16'd20,  12'd1000, 12'd4000, 1'b0, 1'b0, 1'b0, 14'd3500, 12'd1,    12'd4,    7'b0011000},
    '{16'd74,  12'd7,    12'd4095, 1'b0, 1'b1, 1'b1, 14'd3600, 12'd1,    12'd585,  7'b0010100},
    '{16'd75,  12'd2,    12'd6,    1'b1, 1'b1, 1'b0, 14'd3000, 12'd17,   12'd51,   7'b0000110},
    '{16'd23,  12'd4094, 12'd4095, 1'b1, 1'b0, 1'b0, 14'd100,  12'd4094, 12'd4095, 7'b0000100},
    '{16'd200, 12'd0,    12'd10,   1'b1, 1'b0, 1'b0, 14'd0,    12'd0,    12'd50,   7'b1000110},
    '{16'd30,  12'd5,    12'd1,    1'b0, 1'b0, 1'b0, 14'd0,    12'd5,    12'd1,    7'b0100100},
    '{16'd30,  12'd0,    12'd0,    1'b1, 1'b0, 1'b0, 14'd0,    12'd0,    12'd0,    7'b1100100},
    '{16'd100, 12'd25,   12'd50,   1'b1, 1'b1, 1'b1, 14'd3601, 12'd25,   12'd50,   7'b0000010},
    '{16'd30,  12'd3,    12'd9,    1'b0, 1'b0, 1'b0, 14'd3001, 12'd1,    12'd3,    7'b0001000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] n_int = '0;
  logic [11:0] frac_in = '0, mod_in = '0;
  logic        low_spur_req = 1'b0, presc_89_sel = 1'b0, variant_sel = 1'b0;
  logic [13:0] presc_in_mhz = '0;
  logic        busy, done, int_mode, err_invalid, err_n_min, err_presc;
  logic        legal_45, legal_89, err_low_spur;
  logic [11:0] frac_out, mod_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  frac_ratio_reducer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_int(n_int),
    .frac_in(frac_in), .mod_in(mod_in), .low_spur_req(low_spur_req),
    .presc_89_sel(presc_89_sel), .variant_sel(variant_sel),
    .presc_in_mhz(presc_in_mhz), .busy(busy), .done(done),
    .frac_out(frac_out), .mod_out(mod_out), .int_mode(int_mode),
    .err_invalid(err_invalid), .err_n_min(err_n_min), .err_presc(err_presc),
    .legal_45(legal_45), .legal_89(legal_89), .err_low_spur(err_low_spur)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    n_int = v.n; frac_in = v.fr; mod_in = v.md;
    low_spur_req = v.ls; presc_89_sel = v.p89; variant_sel = v.vr;
    presc_in_mhz = v.pin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    ok = done;
    if (!ok) check("R8 done timeout", 0, 1);
  endtask

  task automatic compare(input vec_t v);
    check("R1 frac_out", int'(frac_out), int'(v.efr));
    check("R1 mod_out", int'(mod_out), int'(v.emd));
    check("R2 int_mode", int'(int_mode), int'(v.efl[6]));
    check("R3 err_invalid", int'(err_invalid), int'(v.efl[5]));
    check("R4 err_n_min", int'(err_n_min), int'(v.efl[4]));
    check("R5 err_presc", int'(err_presc), int'(v.efl[3]));
    check("R6 legal_45", int'(legal_45), int'(v.efl[2]));
    check("R6 legal_89", int'(legal_89), int'(v.efl[1]));
    check("R7 err_low_spur", int'(err_low_spur), int'(v.efl[0]));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit ok;
    vec_t alt;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    check("R9 mod_out", int'(mod_out), 0);
    check("R9 frac_out", int'(frac_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 busy after release", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      wait_done(ok);
      if (ok) compare(VECS[i]);
    end

    // R8: busy during run, start while busy ignored, done lasts one cycle
    issue(VECS[0]);
    check("R8 busy after accept", int'(busy), 1);
    alt = VECS[3];
    @(negedge clk);
    n_int = alt.n; frac_in = alt.fr; mod_in = alt.md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      check("R8 ignored start frac", int'(frac_out), 3);
      check("R8 ignored start mod", int'(mod_out), 4);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
      check("R8 busy released", int'(busy), 0);
      check("R8 result held", int'(mod_out), 4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule